// File: doc/BRIEF.md
# Multi-channel DMA register front end

This block is the software-facing register file for a four-channel DMA engine that sits on a byte-wide memory-mapped I/O bus. Each channel holds a programmed 32-bit source address, a 32-bit destination address, a 16-bit transfer count and a 16-bit control word. The write port loads these one byte at a time. The read port returns only the control bytes.

When a control write turns a channel's enable bit on, the block copies the programmed source, destination and count into a separate set of working registers. The transfer engine consumes the working set, so software may reprogram the next transfer while the current one runs. If the start-timing field selects immediate start, the same write raises the channel's pending request. The engine drops the request through a per-channel clear input when it finishes.

The channel windows are packed back to back in a local byte address space. The working values, the live control word and the pending flag of every channel are exported as flat vectors, one slice per channel.

Top module: `dma_regfront`

## Requirements
- R1: After reset, all programmed and working registers, every pending flag and the read data output are zero.
- R2: Channel c occupies byte addresses 12*c to 12*c+11. Source is at +0..+3, destination at +4..+7, count at +8..+9 and control at +10..+11, with the lowest address holding the least significant byte. For four channels, an address of 48 or more is unmapped: a write to it changes no register and no output, and a read from it returns zero.
- R3: A byte write replaces only the addressed byte lane of the target register and leaves its other bytes unchanged.
- R4: rd_data shows, one clock edge after rd_addr is presented, the addressed control byte. A read of a source, destination or count byte returns zero.
- R5: A control write that changes bit 15 (enable) from 0 to 1 copies the programmed source, destination and count into run_src, run_dst and run_cnt at that same clock edge. Before such a write, the working outputs keep their previous values.
- R6: On that 0-to-1 enable write, the channel's pending flag is set if control bits 13:12 (start timing) are 00. For any other timing value it stays clear. A pending flag is only ever set while the channel's enable bit is 1.
- R7: Any control write that leaves the enable bit at 0 clears that channel's pending flag.
- R8: A control write that keeps the enable bit at 1 does not copy into the working registers and does not change the pending flag.
- R9: A one-cycle pulse on pend_clr[c] clears pending flag c. If a 0-to-1 immediate enable write to the same channel lands in the same cycle, the flag is set.
- R10: run_ctl carries each channel's current control word and follows every control byte write at the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write address within the register window |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 8 | Byte read address |
| rd_data | output | 8 | Registered read data |
| pend_clr | input | 4 | Per-channel pending clear from the transfer engine |
| run_src | output | 128 | Working source address, 32 bits per channel |
| run_dst | output | 128 | Working destination address, 32 bits per channel |
| run_cnt | output | 64 | Working transfer count, 16 bits per channel |
| run_ctl | output | 64 | Current control word, 16 bits per channel |
| pend | output | 4 | Per-channel pending request |

## Verification
A write takes effect at the rising edge that captures it. The programmed registers, the working copies, run_ctl and the pending flags all change at that edge, so these results are due with zero cycles of delay. rd_data passes through one register and is due one edge after rd_addr is applied. The bench drives every input on a falling edge and samples on the following falling edge, which is half a cycle after the edge where each result lands. Programmed source, destination and count are never read back, so lane preservation is checked through the working copies after an enable write.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;

  // Control word layout: behaviour depends on these positions.
  localparam int CTL_W      = 16;
  localparam int CTL_B      = CTL_W / 8;
  localparam int CTL_EN     = 15;
  localparam int CTL_TIM_LO = 12;
  localparam int CTL_TIM_HI = 13;

  // Register field within one channel window.
  typedef enum logic [1:0] {
    FLD_SRC = 2'd0,
    FLD_DST = 2'd1,
    FLD_CNT = 2'd2,
    FLD_CTL = 2'd3
  } fld_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
  import dma_regfront_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int ADR_B  = 4,
  parameter int CNT_B  = 2,
  parameter int LANE_W = 2,
  parameter int STRIDE = 12,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [NUM_CH-1:0] sel,
  output fld_e              fld,
  output logic [LANE_W-1:0] lane
);

  localparam int DST_OFF = ADR_B;
  localparam int CNT_OFF = 2 * ADR_B;
  localparam int CTL_OFF = 2 * ADR_B + CNT_B;

  logic [OFF_W-1:0] off;

  // Channel select: one comparison window per channel.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    off = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if ((int'(addr) >= c * STRIDE) && (int'(addr) < (c + 1) * STRIDE)) begin
        hit    = 1'b1;
        sel[c] = 1'b1;
        off    = OFF_W'(int'(addr) - c * STRIDE);
      end
    end
  end

  // Field and byte lane within the selected channel window.
  always_comb begin
    if (int'(off) < DST_OFF) begin
      fld  = FLD_SRC;
      lane = LANE_W'(int'(off));
    end else if (int'(off) < CNT_OFF) begin
      fld  = FLD_DST;
      lane = LANE_W'(int'(off) - DST_OFF);
    end else if (int'(off) < CTL_OFF) begin
      fld  = FLD_CNT;
      lane = LANE_W'(int'(off) - CNT_OFF);
    end else begin
      fld  = FLD_CTL;
      lane = LANE_W'(int'(off) - CTL_OFF);
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfront_pkg::*;
#(
  parameter int ADR_W  = 32,
  parameter int CNT_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  fld_e              fld,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wdata,
  input  logic              pend_clr,
  output logic [ADR_W-1:0]  run_src,
  output logic [ADR_W-1:0]  run_dst,
  output logic [CNT_W-1:0]  run_cnt,
  output logic [CTL_W-1:0]  ctl,
  output logic              pend
);

  localparam int ADR_B = ADR_W / 8;
  localparam int CNT_B = CNT_W / 8;

  // Programmed registers
  logic [ADR_W-1:0] src_q, src_d;
  logic [ADR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  // Working copies
  logic [ADR_W-1:0] run_src_q;
  logic [ADR_W-1:0] run_dst_q;
  logic [CNT_W-1:0] run_cnt_q;
  logic             pend_q, pend_d;

  logic ctl_we;
  logic en_rise;
  logic en_off;
  logic tim_imm;

  // Byte-lane merge of the write into the programmed registers.
  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    ctl_d = ctl_q;
    unique case (fld)
      FLD_SRC: begin
        for (int b = 0; b < ADR_B; b++) begin
          if (int'(lane) == b) src_d[b*8 +: 8] = wdata;
        end
      end
      FLD_DST: begin
        for (int b = 0; b < ADR_B; b++) begin
          if (int'(lane) == b) dst_d[b*8 +: 8] = wdata;
        end
      end
      FLD_CNT: begin
        for (int b = 0; b < CNT_B; b++) begin
          if (int'(lane) == b) cnt_d[b*8 +: 8] = wdata;
        end
      end
      default: begin
        for (int b = 0; b < CTL_B; b++) begin
          if (int'(lane) == b) ctl_d[b*8 +: 8] = wdata;
        end
      end
    endcase
  end

  // Enable transition detection and pending next state.
  always_comb begin
    ctl_we  = we && (fld == FLD_CTL);
    en_rise = ctl_we && !ctl_q[CTL_EN] && ctl_d[CTL_EN];
    en_off  = ctl_we && !ctl_d[CTL_EN];
    tim_imm = (ctl_d[CTL_TIM_HI:CTL_TIM_LO] == 2'b00);
    pend_d  = pend_q;
    if (pend_clr) pend_d = 1'b0;
    if (en_off)   pend_d = 1'b0;
    if (en_rise && tim_imm) pend_d = 1'b1;
  end

  // Programmed register bank, clock enable = write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else if (we) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
    end
  end

  // Working copies, clock enable = enable rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_src_q <= '0;
      run_dst_q <= '0;
      run_cnt_q <= '0;
    end else if (en_rise) begin
      run_src_q <= src_q;
      run_dst_q <= dst_q;
      run_cnt_q <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign run_src = run_src_q;
  assign run_dst = run_dst_q;
  assign run_cnt = run_cnt_q;
  assign ctl     = ctl_q;
  assign pend    = pend_q;

  // R3: a low-lane source write preserves the upper bytes
  a_r3_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (we && fld == FLD_SRC && lane == '0) |=> (src_q[ADR_W-1:8] == $past(src_q[ADR_W-1:8])));

  // R5: working set equals the programmed set seen before the enabling write
  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (run_src_q == $past(src_q)) && (run_dst_q == $past(dst_q)) && (run_cnt_q == $past(cnt_q)));

  // R6: immediate timing raises the request
  a_r6_imm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && ctl_d[CTL_TIM_HI:CTL_TIM_LO] == 2'b00) |=> pend_q);

  // R6: non-immediate timing leaves the request low
  a_r6_timed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && ctl_d[CTL_TIM_HI:CTL_TIM_LO] != 2'b00) |=> !pend_q);

  // R6: a request never exists on a disabled channel
  a_r6_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> ctl_q[CTL_EN]);

  // R7: writing control with enable low drops the request
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_d[CTL_EN]) |=> !pend_q);

  // R8: rewriting an enabled channel neither re-snapshots nor touches pending
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_q[CTL_EN] && ctl_d[CTL_EN] && !pend_clr)
      |=> $stable(run_src_q) && $stable(run_dst_q) && $stable(run_cnt_q) && $stable(pend_q));

  // R9: engine clear wins unless an immediate enable lands together
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !en_rise) |=> !pend_q);

endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_regfront_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LANE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit,
  input  logic [NUM_CH-1:0]       sel,
  input  fld_e                    fld,
  input  logic [LANE_W-1:0]       lane,
  input  logic [NUM_CH*CTL_W-1:0] ctl_all,
  output logic [7:0]              rd_data
);

  logic [7:0] rd_d;
  logic [7:0] rd_q;

  // Only control bytes are visible; everything else reads as zero.
  always_comb begin
    rd_d = 8'h00;
    if (hit && fld == FLD_CTL) begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < CTL_B; b++) begin
          if (sel[c] && int'(lane) == b) rd_d = ctl_all[c*CTL_W + b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 8'h00;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R4: non-control fields read as zero
  a_r4_noncontrol_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fld != FLD_CTL) |=> (rd_q == 8'h00));

endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
  import dma_regfront_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int ADR_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  input  logic [NUM_CH-1:0]       pend_clr,
  output logic [NUM_CH*ADR_W-1:0] run_src,
  output logic [NUM_CH*ADR_W-1:0] run_dst,
  output logic [NUM_CH*CNT_W-1:0] run_cnt,
  output logic [NUM_CH*CTL_W-1:0] run_ctl,
  output logic [NUM_CH-1:0]       pend
);

  localparam int ADR_B  = ADR_W / 8;
  localparam int CNT_B  = CNT_W / 8;
  localparam int STRIDE = 2 * ADR_B + CNT_B + CTL_B;
  localparam int OFF_W  = $clog2(STRIDE);
  localparam int LANE_W = (ADR_B > 1) ? $clog2(ADR_B) : 1;

  logic rst_sync_n;

  logic              wr_hit;
  logic [NUM_CH-1:0] wr_sel;
  fld_e              wr_fld;
  logic [LANE_W-1:0] wr_lane;

  logic              rd_hit;
  logic [NUM_CH-1:0] rd_sel;
  fld_e              rd_fld;
  logic [LANE_W-1:0] rd_lane;

  dma_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_addr_dec #(
    .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .ADR_B (ADR_B), .CNT_B (CNT_B),
    .LANE_W (LANE_W), .STRIDE (STRIDE), .OFF_W (OFF_W)
  ) u_wr_dec (
    .addr (wr_addr),
    .hit  (wr_hit),
    .sel  (wr_sel),
    .fld  (wr_fld),
    .lane (wr_lane)
  );

  dma_addr_dec #(
    .NUM_CH (NUM_CH), .ADDR_W (ADDR_W), .ADR_B (ADR_B), .CNT_B (CNT_B),
    .LANE_W (LANE_W), .STRIDE (STRIDE), .OFF_W (OFF_W)
  ) u_rd_dec (
    .addr (rd_addr),
    .hit  (rd_hit),
    .sel  (rd_sel),
    .fld  (rd_fld),
    .lane (rd_lane)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs #(
      .ADR_W (ADR_W), .CNT_W (CNT_W), .LANE_W (LANE_W)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .we       (wr_en && wr_hit && wr_sel[c]),
      .fld      (wr_fld),
      .lane     (wr_lane),
      .wdata    (wr_data),
      .pend_clr (pend_clr[c]),
      .run_src  (run_src[c*ADR_W +: ADR_W]),
      .run_dst  (run_dst[c*ADR_W +: ADR_W]),
      .run_cnt  (run_cnt[c*CNT_W +: CNT_W]),
      .ctl      (run_ctl[c*CTL_W +: CTL_W]),
      .pend     (pend[c])
    );
  end

  dma_rd_mux #(
    .NUM_CH (NUM_CH), .LANE_W (LANE_W)
  ) u_rd_mux (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit     (rd_hit),
    .sel     (rd_sel),
    .fld     (rd_fld),
    .lane    (rd_lane),
    .ctl_all (run_ctl),
    .rd_data (rd_data)
  );

  // R2: decoded channel select is never ambiguous
  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_sel) && $onehot0(rd_sel));

  // R2: unmapped reads return zero
  a_r2_unmapped_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(rd_addr) >= NUM_CH * STRIDE) |=> (rd_data == 8'h00));

  // R2: unmapped writes leave every control word alone
  a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && int'(wr_addr) >= NUM_CH * STRIDE) |=> $stable(run_ctl));

endmodule

// File: tb/dma_regfront_tb.sv
module dma_regfront_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_addr;
  logic [7:0]   wr_data;
  logic [7:0]   rd_addr;
  logic [7:0]   rd_data;
  logic [3:0]   pend_clr;
  logic [127:0] run_src;
  logic [127:0] run_dst;
  logic [63:0]  run_cnt;
  logic [63:0]  run_ctl;
  logic [3:0]   pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dma_regfront dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .pend_clr (pend_clr), .run_src (run_src), .run_dst (run_dst),
    .run_cnt (run_cnt), .run_ctl (run_ctl), .pend (pend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, captured at the next rising edge, return on the following falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pend", {28'h0, pend}, 32'h0);
    check("R1 run_src", run_src[63:32], 32'h0);
    check("R1 run_ctl", run_ctl[31:16], 32'h0);
    rd(8'd22, d);
    check("R1 rd_data", {24'h0, d}, 32'h0);
  endtask

  task automatic t_snapshot();
    wr(8'd12, 8'h11); wr(8'd13, 8'h22); wr(8'd14, 8'h33); wr(8'd15, 8'h44);
    wr(8'd13, 8'h99);
    wr(8'd16, 8'hA0); wr(8'd17, 8'hB0); wr(8'd18, 8'hC0); wr(8'd19, 8'hD0);
    wr(8'd20, 8'h34); wr(8'd21, 8'h12);
    wr(8'd22, 8'h05);
    check("R5 no copy before enable", run_src[63:32], 32'h0);
    wr(8'd23, 8'h80);
    check("R3 R5 run_src ch1", run_src[63:32], 32'h44339911);
    check("R5 run_dst ch1", run_dst[63:32], 32'hD0C0B0A0);
    check("R5 run_cnt ch1", {16'h0, run_cnt[31:16]}, 32'h1234);
    check("R10 run_ctl ch1", {16'h0, run_ctl[31:16]}, 32'h8005);
    check("R6 pend immediate", {28'h0, pend}, 32'h2);
  endtask

  task automatic t_read();
    logic [7:0] d;
    rd(8'd22, d); check("R4 ctl low", {24'h0, d}, 32'h05);
    rd(8'd23, d); check("R4 ctl high", {24'h0, d}, 32'h80);
    rd(8'd12, d); check("R4 src reads zero", {24'h0, d}, 32'h0);
    rd(8'd17, d); check("R4 dst reads zero", {24'h0, d}, 32'h0);
    rd(8'd20, d); check("R4 cnt reads zero", {24'h0, d}, 32'h0);
  endtask

  task automatic t_hold();
    wr(8'd12, 8'h77);
    wr(8'd23, 8'h90);
    check("R8 no re-snapshot", run_src[63:32], 32'h44339911);
    check("R8 pend kept", {28'h0, pend}, 32'h2);
    check("R10 run_ctl follows", {16'h0, run_ctl[31:16]}, 32'h9005);
  endtask

  task automatic t_clear();
    @(negedge clk); pend_clr = 4'b0010;
    @(negedge clk); pend_clr = 4'b0000;
    check("R9 engine clear", {28'h0, pend}, 32'h0);
  endtask

  task automatic t_disable();
    wr(8'd23, 8'h00);
    check("R7 disable pend", {28'h0, pend}, 32'h0);
    wr(8'd23, 8'h80);
    check("R5 re-snapshot", run_src[63:32], 32'h44339977);
    check("R6 re-enable pend", {28'h0, pend}, 32'h2);
    wr(8'd23, 8'h00);
    check("R7 enable off clears", {28'h0, pend}, 32'h0);
  endtask

  task automatic t_timed();
    wr(8'd24, 8'h5A);
    wr(8'd35, 8'hA0);
    check("R6 timed no pend", {28'h0, pend}, 32'h0);
    check("R5 timed snapshot", run_src[95:64], 32'h0000005A);
  endtask

  task automatic t_prio();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd47; wr_data = 8'h80; pend_clr = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; pend_clr = 4'b0000;
    check("R9 set beats clear", {28'h0, pend}, 32'h8);
    check("R2 ch3 control", {16'h0, run_ctl[63:48]}, 32'h8000);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [63:0] ctl_before;
    wr(8'd11, 8'h80);
    check("R2 ch0 control", {16'h0, run_ctl[15:0]}, 32'h8000);
    check("R2 ch0 pend", {28'h0, pend}, 32'h9);
    ctl_before = run_ctl;
    wr(8'd48, 8'hFF);
    wr(8'd200, 8'hFF);
    check("R2 unmapped write ctl lo", run_ctl[31:0], ctl_before[31:0]);
    check("R2 unmapped write ctl hi", run_ctl[63:32], ctl_before[63:32]);
    check("R2 unmapped write pend", {28'h0, pend}, 32'h9);
    rd(8'd48, d);
    check("R2 unmapped read", {24'h0, d}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; pend_clr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_snapshot();
    t_read();
    t_hold();
    t_clear();
    t_disable();
    t_timed();
    t_prio();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule